// File: doc/BRIEF.md
# Two-Phase Indexed Register Bridge

This block is a register-file slave that sits behind a narrow host bus of the kind built from general-purpose pins. The bus has an 8-bit data path, split here into an input byte, an output byte and a drive enable. It also has four control lines and a ready line: chip select, write strobe, read strobe, and an address/data select that is active high. Chip select, both strobes and ready are all active low. Every register access takes two bus cycles. The first is a write cycle with the select high, which loads a register index. The second is a data cycle with the select low, which reads or writes the register that the index points to. The index is kept between cycles, so the host can repeat data cycles to the same register without sending the index again.

All bus lines pass through a synchroniser chain into the core clock before they are used. A small handshake state machine runs every access. It has four states. `ST_IDLE` waits for a strobe. `ST_IDX_HOLD` follows an index write. `ST_WR_HOLD` follows a data write. `ST_RD_HOLD` follows a data read. The transitions are as follows:

- `ST_IDLE` goes to `ST_IDX_HOLD` when a write is seen with the select high.
- `ST_IDLE` goes to `ST_WR_HOLD` when a write is seen with the select low.
- `ST_IDLE` goes to `ST_RD_HOLD` when a read is seen. A write takes priority if both strobes are low.
- Each hold state returns to `ST_IDLE` once both strobes are released.

The register action happens once, on the transition out of `ST_IDLE`. Ready is low in every hold state.

Behind the state machine is a decoded register map. It has bus control registers, a card address pair, a card data port forwarded to the slot controller, a filter table address pair, a filter table data port forwarded to the PID filter, two stream clock dividers, a read-only revision byte, and an interrupt control register. The interrupt control register holds the interrupt enable and the pending flag.

Top module: `ibr_bridge`

## Requirements
- R1: After reset, `bus_rdy_n` and `irq_n` are 1, `bus_doe` is 0, and all register outputs (`slot_addr`, `pid_addr`, `bus_ctl`, `bus_ctl2`, `div_a`, `div_b`) are 0.
- R2: While chip select is low, a strobe driven low makes `bus_rdy_n` fall on the third rising clock edge after it. `bus_rdy_n` stays low for as long as the strobe is held, and rises on the third rising edge after the strobe is released. One strobe assertion performs exactly one access.
- R3: A write cycle with `bus_sel`=1 loads the register index from the data byte. Every following data cycle (`bus_sel`=0) targets that index until a new index is loaded.
- R4: Indices 0x01, 0x07, 0x04/0x05, 0x08/0x09, 0x0C and 0x0D are plain read/write bytes. They drive `bus_ctl2`, `bus_ctl`, `slot_addr` (0x05 is the high byte), `pid_addr` (0x09 is the high byte), `div_a` and `div_b`.
- R5: A data write to index 0x06 gives a one-cycle `slot_wr` pulse with the byte on `wr_byte`. A data read of 0x06 returns `slot_rdata` and gives a one-cycle `slot_rd` pulse.
- R6: A data write to index 0x0A gives a one-cycle `pid_wr` pulse with the byte on `wr_byte`. A data read of 0x0A returns `pid_rdata` and gives a one-cycle `pid_rd` pulse.
- R7: Index 0x0F reads as the parameter `REV`. Writes to it have no effect.
- R8: Any other index reads as 0x00, and writes to it change no register.
- R9: Index 0x00 reads as {pending, ctrl[6:0]}, and a write stores bits 6..0 into ctrl. An `irq_evt` pulse sets pending. `irq_n` is 0 exactly when pending is set and ctrl bits 6 and 2 are both 1, so writing 0x44 enables the interrupt.
- R10: A data read of index 0x00 clears the pending flag after returning it.
- R11: `bus_doe` is 1 only while a data read is holding ready low, and `bus_dout` then carries the read value. During writes `bus_doe` is 0.
- R12: While `bus_cs_n` is 1, the strobes are ignored: there is no ready, no pulse and no register change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_sel | input | 1 | 1 = index cycle, 0 = data cycle |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_din | input | DW | Byte from host |
| bus_dout | output | DW | Byte to host |
| bus_doe | output | 1 | Drive enable for `bus_dout` |
| bus_rdy_n | output | 1 | Cycle done, active low |
| irq_evt | input | 1 | Interrupt event pulse from slot logic |
| irq_n | output | 1 | Interrupt request, active low |
| slot_addr | output | 2*DW | Card address |
| slot_wr | output | 1 | Card data write pulse |
| slot_rd | output | 1 | Card data read pulse |
| slot_rdata | input | DW | Card read data |
| pid_addr | output | 2*DW | Filter table address |
| pid_wr | output | 1 | Filter table write pulse |
| pid_rd | output | 1 | Filter table read pulse |
| pid_rdata | input | DW | Filter table read data |
| wr_byte | output | DW | Byte carried by a forwarded write |
| bus_ctl | output | DW | Bus control byte |
| bus_ctl2 | output | DW | Bus control 2 byte |
| div_a | output | DW | Stream A clock divider |
| div_b | output | DW | Stream B clock divider |

## Verification
The bench builds the bridge with `REV` = 0xA5 and keeps the default two-stage synchroniser and 8-bit data path. These values make the read-only byte distinct from reset and from every written pattern, and they fix the ready latency at three clock edges, which the bench measures exactly. With an 8-bit index, the bench also reaches unmapped indices both inside and beyond the decoded range (0x03, 0x0E, 0x10).

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_IDX_HOLD,
        ST_WR_HOLD,
        ST_RD_HOLD
    } bus_st_t;

    // Register indices (the host's driver decodes these values)
    localparam logic [7:0] IX_IRQ     = 8'h00;
    localparam logic [7:0] IX_CTL2    = 8'h01;
    localparam logic [7:0] IX_CADR_LO = 8'h04;
    localparam logic [7:0] IX_CADR_HI = 8'h05;
    localparam logic [7:0] IX_CDAT    = 8'h06;
    localparam logic [7:0] IX_CTL     = 8'h07;
    localparam logic [7:0] IX_PADR_LO = 8'h08;
    localparam logic [7:0] IX_PADR_HI = 8'h09;
    localparam logic [7:0] IX_PDAT    = 8'h0A;
    localparam logic [7:0] IX_DIV_A   = 8'h0C;
    localparam logic [7:0] IX_DIV_B   = 8'h0D;
    localparam logic [7:0] IX_REV     = 8'h0F;

    // Plain storage bytes, in slot order
    localparam int NPLAIN = 8;
    localparam int PL_CTL2    = 0;
    localparam int PL_CADR_LO = 1;
    localparam int PL_CADR_HI = 2;
    localparam int PL_CTL     = 3;
    localparam int PL_PADR_LO = 4;
    localparam int PL_PADR_HI = 5;
    localparam int PL_DIV_A   = 6;
    localparam int PL_DIV_B   = 7;

    // Interrupt enable bits inside the control byte
    localparam int IRQ_EN_A = 6;
    localparam int IRQ_EN_B = 2;

endpackage

// File: rtl/ibr_sync.sv
module ibr_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar s = 0; s < STAGES; s++) begin : g_st
        logic [W-1:0] r;
        logic [W-1:0] src;
        if (s == 0) begin : g_first
            assign src = d;
        end else begin : g_next
            assign src = g_st[s-1].r;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= src;
        end
    end

    assign q = g_st[STAGES-1].r;

endmodule

// File: rtl/ibr_bus_fsm.sv
module ibr_bus_fsm
    import ibr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sel,
    input  logic wr_n,
    input  logic rd_n,
    output logic idx_ld,
    output logic wr_fire,
    output logic rd_fire,
    output logic rdy_n,
    output logic d_oe
);

    bus_st_t st_q, st_nx;
    logic    wr_act, rd_act;

    assign wr_act = !cs_n && !wr_n;
    assign rd_act = !cs_n && !rd_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (wr_act)      st_nx = sel ? ST_IDX_HOLD : ST_WR_HOLD;
                else if (rd_act) st_nx = ST_RD_HOLD;
            end
            ST_IDX_HOLD,
            ST_WR_HOLD,
            ST_RD_HOLD: begin
                if (!wr_act && !rd_act) st_nx = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        idx_ld  = 1'b0;
        wr_fire = 1'b0;
        rd_fire = 1'b0;
        rdy_n   = 1'b0;
        d_oe    = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                rdy_n   = 1'b1;
                idx_ld  = wr_act && sel;
                wr_fire = wr_act && !sel;
                rd_fire = !wr_act && rd_act;
            end
            ST_IDX_HOLD, ST_WR_HOLD: ;
            ST_RD_HOLD: d_oe = 1'b1;
        endcase
    end

    // R2
    fire_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_ld || wr_fire || rd_fire) |=> !rdy_n);
    // R2
    hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_n && (wr_act || rd_act)) |=> (!rdy_n && !idx_ld && !wr_fire && !rd_fire));
    // R2
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({idx_ld, wr_fire, rd_fire}));
    // R12
    deselect_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_n && cs_n) |=> rdy_n);
    // R11
    drive_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        d_oe |-> (!rdy_n && !wr_fire));

endmodule

// File: rtl/ibr_irq.sv
module ibr_irq
    import ibr_pkg::*;
#(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          evt,
    input  logic          clr,
    input  logic          ctrl_we,
    input  logic [CW-1:0] ctrl_wd,
    output logic          pending,
    output logic [CW-1:0] ctrl,
    output logic          irq_n
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            pending <= 1'b0;
        end else begin
            if (ctrl_we) ctrl <= ctrl_wd;
            if (evt)      pending <= 1'b1;
            else if (clr) pending <= 1'b0;
        end
    end

    assign irq_n = !(pending && ctrl[IRQ_EN_A] && ctrl[IRQ_EN_B]);

    // R9
    evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pending);
    // R10
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !pending);
    // R9
    irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> pending);

endmodule

// File: rtl/ibr_regs.sv
module ibr_regs
    import ibr_pkg::*;
#(
    parameter int            DW  = 8,
    parameter logic [DW-1:0] REV = 8'h21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idx_ld,
    input  logic            wr_fire,
    input  logic            rd_fire,
    input  logic [DW-1:0]   din,
    input  logic [DW-1:0]   slot_rdata,
    input  logic [DW-1:0]   pid_rdata,
    input  logic            irq_pend,
    input  logic [DW-2:0]   irq_ctrl,
    output logic            irq_ctrl_we,
    output logic            irq_clr,
    output logic [DW-1:0]   dout,
    output logic            slot_wr,
    output logic            slot_rd,
    output logic            pid_wr,
    output logic            pid_rd,
    output logic [2*DW-1:0] slot_addr,
    output logic [2*DW-1:0] pid_addr,
    output logic [DW-1:0]   ctl,
    output logic [DW-1:0]   ctl2,
    output logic [DW-1:0]   div_a,
    output logic [DW-1:0]   div_b
);

    localparam logic [7:0] PLAIN_IX [NPLAIN] = '{
        IX_CTL2, IX_CADR_LO, IX_CADR_HI, IX_CTL,
        IX_PADR_LO, IX_PADR_HI, IX_DIV_A, IX_DIV_B
    };

    logic [DW-1:0]              idx_q;
    logic [NPLAIN-1:0][DW-1:0]  plain_q;
    logic [DW-1:0]              rd_val;
    logic                       mapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_ld) idx_q <= din;
    end

    for (genvar i = 0; i < NPLAIN; i++) begin : g_pl
        logic [DW-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             q <= '0;
            else if (wr_fire && idx_q == PLAIN_IX[i]) q <= din;
        end
        assign plain_q[i] = q;
    end

    always_comb begin
        mapped = 1'b0;
        rd_val = '0;
        for (int i = 0; i < NPLAIN; i++) begin
            if (idx_q == PLAIN_IX[i]) begin
                mapped = 1'b1;
                rd_val = plain_q[i];
            end
        end
        unique case (idx_q)
            IX_IRQ:  begin mapped = 1'b1; rd_val = {irq_pend, irq_ctrl}; end
            IX_CDAT: begin mapped = 1'b1; rd_val = slot_rdata; end
            IX_PDAT: begin mapped = 1'b1; rd_val = pid_rdata; end
            IX_REV:  begin mapped = 1'b1; rd_val = REV; end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dout <= '0;
        else if (rd_fire) dout <= rd_val;
    end

    assign irq_ctrl_we = wr_fire && idx_q == IX_IRQ;
    assign irq_clr     = rd_fire && idx_q == IX_IRQ;
    assign slot_wr     = wr_fire && idx_q == IX_CDAT;
    assign slot_rd     = rd_fire && idx_q == IX_CDAT;
    assign pid_wr      = wr_fire && idx_q == IX_PDAT;
    assign pid_rd      = rd_fire && idx_q == IX_PDAT;

    assign slot_addr = {plain_q[PL_CADR_HI], plain_q[PL_CADR_LO]};
    assign pid_addr  = {plain_q[PL_PADR_HI], plain_q[PL_PADR_LO]};
    assign ctl       = plain_q[PL_CTL];
    assign ctl2      = plain_q[PL_CTL2];
    assign div_a     = plain_q[PL_DIV_A];
    assign div_b     = plain_q[PL_DIV_B];

    // R3
    index_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_ld |=> (idx_q == $past(din)));
    // R8
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && !mapped) |=> $stable(plain_q));
    // R7
    revision_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && idx_q == IX_REV) |=> (dout == REV));
    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && !mapped) |=> (dout == '0));

endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int            DW          = 8,
    parameter int            SYNC_STAGES = 2,
    parameter logic [DW-1:0] REV         = 8'h21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_cs_n,
    input  logic            bus_sel,
    input  logic            bus_wr_n,
    input  logic            bus_rd_n,
    input  logic [DW-1:0]   bus_din,
    output logic [DW-1:0]   bus_dout,
    output logic            bus_doe,
    output logic            bus_rdy_n,
    input  logic            irq_evt,
    output logic            irq_n,
    output logic [2*DW-1:0] slot_addr,
    output logic            slot_wr,
    output logic            slot_rd,
    input  logic [DW-1:0]   slot_rdata,
    output logic [2*DW-1:0] pid_addr,
    output logic            pid_wr,
    output logic            pid_rd,
    input  logic [DW-1:0]   pid_rdata,
    output logic [DW-1:0]   wr_byte,
    output logic [DW-1:0]   bus_ctl,
    output logic [DW-1:0]   bus_ctl2,
    output logic [DW-1:0]   div_a,
    output logic [DW-1:0]   div_b
);

    localparam int NCTL = 4;

    logic [NCTL-1:0] ctl_raw, ctl_s;
    logic [DW-1:0]   din_s;
    logic            cs_s, sel_s, wr_s, rd_s;
    logic            idx_ld, wr_fire, rd_fire;
    logic            irq_ctrl_we, irq_clr, irq_pend;
    logic [DW-2:0]   irq_ctrl;

    assign ctl_raw = {bus_cs_n, bus_sel, bus_wr_n, bus_rd_n};
    assign {cs_s, sel_s, wr_s, rd_s} = ctl_s;

    ibr_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL(4'b1011)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
    );

    ibr_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_din), .q(din_s)
    );

    ibr_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cs_n(cs_s), .sel(sel_s), .wr_n(wr_s), .rd_n(rd_s),
        .idx_ld(idx_ld), .wr_fire(wr_fire), .rd_fire(rd_fire),
        .rdy_n(bus_rdy_n), .d_oe(bus_doe)
    );

    ibr_regs #(.DW(DW), .REV(REV)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .idx_ld(idx_ld), .wr_fire(wr_fire), .rd_fire(rd_fire),
        .din(din_s), .slot_rdata(slot_rdata), .pid_rdata(pid_rdata),
        .irq_pend(irq_pend), .irq_ctrl(irq_ctrl),
        .irq_ctrl_we(irq_ctrl_we), .irq_clr(irq_clr),
        .dout(bus_dout),
        .slot_wr(slot_wr), .slot_rd(slot_rd), .pid_wr(pid_wr), .pid_rd(pid_rd),
        .slot_addr(slot_addr), .pid_addr(pid_addr),
        .ctl(bus_ctl), .ctl2(bus_ctl2), .div_a(div_a), .div_b(div_b)
    );

    ibr_irq #(.CW(DW-1)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .evt(irq_evt), .clr(irq_clr),
        .ctrl_we(irq_ctrl_we), .ctrl_wd(din_s[DW-2:0]),
        .pending(irq_pend), .ctrl(irq_ctrl), .irq_n(irq_n)
    );

    assign wr_byte = din_s;

    // R5
    slot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_wr |=> !slot_wr);
    // R6
    pid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pid_wr |=> !pid_wr);

endmodule

// File: tb/sim_ibr_bridge.sv
module sim_ibr_bridge;

    localparam logic [7:0] TB_REV = 8'hA5;
    localparam logic [1:0] K_A = 2'd0, K_W = 2'd1, K_R = 2'd2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        bus_cs_n = 1'b1, bus_sel = 1'b0, bus_wr_n = 1'b1, bus_rd_n = 1'b1;
    logic [7:0]  bus_din = '0;
    logic [7:0]  bus_dout;
    logic        bus_doe, bus_rdy_n;
    logic        irq_evt = 1'b0;
    logic        irq_n;
    logic [15:0] slot_addr, pid_addr;
    logic        slot_wr, slot_rd, pid_wr, pid_rd;
    logic [7:0]  slot_rdata = '0, pid_rdata = '0;
    logic [7:0]  wr_byte, bus_ctl, bus_ctl2, div_a, div_b;

    ibr_bridge #(.DW(8), .SYNC_STAGES(2), .REV(TB_REV)) u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_cs_n(bus_cs_n), .bus_sel(bus_sel), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n),
        .bus_din(bus_din), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_rdy_n(bus_rdy_n),
        .irq_evt(irq_evt), .irq_n(irq_n),
        .slot_addr(slot_addr), .slot_wr(slot_wr), .slot_rd(slot_rd), .slot_rdata(slot_rdata),
        .pid_addr(pid_addr), .pid_wr(pid_wr), .pid_rd(pid_rd), .pid_rdata(pid_rdata),
        .wr_byte(wr_byte), .bus_ctl(bus_ctl), .bus_ctl2(bus_ctl2),
        .div_a(div_a), .div_b(div_b)
    );

    int n_chk = 0, n_fail = 0;
    int n_swr = 0, n_srd = 0, n_pwr = 0, n_prd = 0;
    logic [7:0] last_sbyte = '0, last_pbyte = '0;

    always @(posedge clk) begin
        if (slot_wr) begin n_swr++; last_sbyte = wr_byte; end
        if (slot_rd) n_srd++;
        if (pid_wr)  begin n_pwr++; last_pbyte = wr_byte; end
        if (pid_rd)  n_prd++;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_cyc(input logic [1:0] kind, input logic [7:0] v, output logic [7:0] rdv);
        int k;
        rdv = '0;
        @(negedge clk);
        bus_cs_n = 1'b0;
        bus_sel  = (kind == K_A);
        bus_din  = v;
        if (kind == K_R) bus_rd_n = 1'b0;
        else             bus_wr_n = 1'b0;
        k = 0;
        while (bus_rdy_n && k < 12) begin @(negedge clk); k++; end
        if (bus_rdy_n) check("R2 ready never fell", 1, 0);
        rdv = bus_dout;
        if (kind == K_R) check("R11 drive enable in read", bus_doe, 1);
        else             check("R11 drive enable in write", bus_doe, 0);
        bus_cs_n = 1'b1; bus_wr_n = 1'b1; bus_rd_n = 1'b1; bus_sel = 1'b0;
        k = 0;
        while (!bus_rdy_n && k < 12) begin @(negedge clk); k++; end
        if (!bus_rdy_n) check("R2 ready never rose", 0, 1);
    endtask

    task automatic set_idx(input logic [7:0] ix);
        logic [7:0] d;
        bus_cyc(K_A, ix, d);
    endtask

    task automatic wr_dat(input logic [7:0] v);
        logic [7:0] d;
        bus_cyc(K_W, v, d);
    endtask

    task automatic rd_dat(output logic [7:0] v);
        bus_cyc(K_R, 8'h00, v);
    endtask

    // {kind, requirement, byte, expected read}
    localparam int NV = 42;
    localparam logic [21:0] VEC [NV] = '{
        {K_A, 4'd3, 8'h01, 8'h00}, {K_W, 4'd4, 8'h5A, 8'h00}, {K_R, 4'd4, 8'h00, 8'h5A}, // R4
        {K_A, 4'd3, 8'h04, 8'h00}, {K_W, 4'd4, 8'h34, 8'h00},
        {K_A, 4'd3, 8'h05, 8'h00}, {K_W, 4'd4, 8'h12, 8'h00},
        {K_A, 4'd3, 8'h04, 8'h00}, {K_R, 4'd4, 8'h00, 8'h34},
        {K_A, 4'd3, 8'h05, 8'h00}, {K_R, 4'd4, 8'h00, 8'h12},
        {K_A, 4'd3, 8'h07, 8'h00}, {K_W, 4'd4, 8'hC3, 8'h00}, {K_R, 4'd4, 8'h00, 8'hC3},
        {K_A, 4'd3, 8'h08, 8'h00}, {K_W, 4'd4, 8'h9A, 8'h00},
        {K_A, 4'd3, 8'h09, 8'h00}, {K_W, 4'd4, 8'h03, 8'h00},
        {K_A, 4'd3, 8'h08, 8'h00}, {K_R, 4'd4, 8'h00, 8'h9A},
        {K_A, 4'd3, 8'h0C, 8'h00}, {K_W, 4'd4, 8'h11, 8'h00},
        {K_A, 4'd3, 8'h0D, 8'h00}, {K_W, 4'd4, 8'h22, 8'h00},
        {K_A, 4'd3, 8'h0C, 8'h00}, {K_R, 4'd4, 8'h00, 8'h11},
        {K_A, 4'd3, 8'h0D, 8'h00}, {K_R, 4'd4, 8'h00, 8'h22},
        {K_A, 4'd3, 8'h0F, 8'h00}, {K_W, 4'd7, 8'hFF, 8'h00}, {K_R, 4'd7, 8'h00, 8'hA5}, // R7
        {K_A, 4'd3, 8'h03, 8'h00}, {K_W, 4'd8, 8'h77, 8'h00}, {K_R, 4'd8, 8'h00, 8'h00}, // R8
        {K_A, 4'd3, 8'h0E, 8'h00}, {K_R, 4'd8, 8'h00, 8'h00},
        {K_A, 4'd3, 8'h10, 8'h00}, {K_W, 4'd8, 8'h66, 8'h00}, {K_R, 4'd8, 8'h00, 8'h00},
        {K_A, 4'd3, 8'h01, 8'h00}, {K_R, 4'd3, 8'h00, 8'h5A}, {K_R, 4'd3, 8'h00, 8'h5A}  // R3
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] r;
        int base;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 rdy_n", bus_rdy_n, 1);
        check("R1 irq_n", irq_n, 1);
        check("R1 doe", bus_doe, 0);
        check("R1 regs", {slot_addr, pid_addr, bus_ctl, bus_ctl2, div_a, div_b}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 after release", {bus_rdy_n, irq_n, bus_doe}, 3'b110);

        for (int i = 0; i < NV; i++) begin
            bus_cyc(VEC[i][21:20], VEC[i][15:8], r);
            if (VEC[i][21:20] == K_R)
                check($sformatf("R%0d table entry %0d", VEC[i][19:16], i), r, VEC[i][7:0]);
        end
        // R4 outputs after the table; R8 unmapped writes left them intact
        check("R4 slot_addr", slot_addr, 16'h1234);
        check("R4 pid_addr", pid_addr, 16'h039A);
        check("R4 ctl/ctl2", {bus_ctl, bus_ctl2}, 16'hC35A);
        check("R4 dividers", {div_a, div_b}, 16'h1122);

        // R5 card data forwarding, R3 index reused without a new index cycle
        set_idx(8'h06);
        base = n_swr;
        wr_dat(8'h5E);
        check("R5 slot_wr count", n_swr - base, 1);
        check("R5 wr_byte", last_sbyte, 8'h5E);
        wr_dat(8'h6F);
        check("R3 repeat data write", n_swr - base, 2);
        check("R3 repeat byte", last_sbyte, 8'h6F);
        slot_rdata = 8'h3C;
        base = n_srd;
        rd_dat(r);
        check("R5 slot read data", r, 8'h3C);
        check("R5 slot_rd count", n_srd - base, 1);

        // R6 filter table forwarding
        set_idx(8'h0A);
        base = n_pwr;
        wr_dat(8'hB7);
        check("R6 pid_wr count", n_pwr - base, 1);
        check("R6 wr_byte", last_pbyte, 8'hB7);
        check("R6 no slot pulse", n_swr, 2);
        pid_rdata = 8'hE1;
        base = n_prd;
        rd_dat(r);
        check("R6 pid read data", r, 8'hE1);
        check("R6 pid_rd count", n_prd - base, 1);

        // R2 exact ready timing, one access per strobe
        set_idx(8'h06);
        base = n_swr;
        @(negedge clk);
        bus_cs_n = 1'b0; bus_din = 8'h42; bus_wr_n = 1'b0;
        @(negedge clk); @(negedge clk);
        check("R2 ready still high after two edges", bus_rdy_n, 1);
        @(negedge clk);
        check("R2 ready low on third edge", bus_rdy_n, 0);
        repeat (6) @(negedge clk);
        check("R2 ready held", bus_rdy_n, 0);
        check("R2 single access per strobe", n_swr - base, 1);
        bus_wr_n = 1'b1; bus_cs_n = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R2 ready low two edges after release", bus_rdy_n, 0);
        @(negedge clk);
        check("R2 ready high on third edge", bus_rdy_n, 1);
        check("R11 no drive after write", bus_doe, 0);

        // R12 deselected strobes ignored
        set_idx(8'h07);
        @(negedge clk);
        bus_cs_n = 1'b1; bus_din = 8'h00; bus_wr_n = 1'b0;
        repeat (8) @(negedge clk);
        check("R12 no ready when deselected", bus_rdy_n, 1);
        bus_wr_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R12 ctl unchanged", bus_ctl, 8'hC3);

        // R9 interrupt enable and pending
        @(negedge clk) irq_evt = 1'b1;
        @(negedge clk) irq_evt = 1'b0;
        @(negedge clk);
        check("R9 no irq while disabled", irq_n, 1);
        set_idx(8'h00);
        wr_dat(8'h44);
        check("R9 irq after 0x44", irq_n, 0);
        rd_dat(r);
        check("R9 read shows pending", r, 8'hC4);
        check("R10 irq dropped by read", irq_n, 1);
        rd_dat(r);
        check("R10 pending cleared", r, 8'h44);
        wr_dat(8'h40);
        @(negedge clk) irq_evt = 1'b1;
        @(negedge clk) irq_evt = 1'b0;
        @(negedge clk);
        check("R9 one enable bit not enough", irq_n, 1);
        wr_dat(8'h44);
        check("R9 irq with both bits", irq_n, 0);
        rd_dat(r);
        check("R10 read clears again", irq_n, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule